// File: doc/BRIEF.md
# Four-Cell Decimating Multiply-Accumulate Array

This block is a systolic engine for finite impulse response filtering. Four identical cells each multiply an 8-bit coefficient by an 8-bit sample and add the product into a private 26-bit accumulator. Every clock, all four cells do this at once, so the array performs four multiply-accumulates per sample clock. One registered sample word is broadcast to every cell.

Coefficients are not broadcast. They enter the first cell, pass through a short delay line inside each cell, and leave the last cell on a cascade output. A second array fed from that output extends the filter. The length of each cell's delay line is set by a mode field. A longer line spaces the cells further apart in time, which lets the array produce output at one half, one third or one quarter of the input rate. Coefficient and sample operands each have their own select that chooses unsigned or two's-complement arithmetic.

Top module: `mac_cell_array`

## Requirements
- R1: While reset (`rstN` low) is applied, and on the first cycle after it is released, every accumulator reads zero and `coefOut` reads zero.
- R2: Each clock with `coefEn` high moves the coefficient chain one step. A value that enters on `coefIn` appears on `coefOut` after exactly 4×(`decMode`+1) enabled clocks. With `coefEn` low, every coefficient register holds its value.
- R3: `decMode` sets the coefficient delay inside each cell: 0 gives 1 stage (no decimation), 1 gives 2 stages (divide by 2), 2 gives 3 stages (divide by 3) and 3 gives 4 stages (divide by 4). The multiplier of cell k uses the coefficient that entered (k+1)×(`decMode`+1) enabled clocks earlier.
- R4: `coefSigned` = 1 treats the coefficient as two's complement and 0 treats it as unsigned. When both selects are 0, every product is non-negative.
- R5: `dataSigned` selects unsigned (0) or two's-complement (1) sample data, independently of `coefSigned`. All four sign combinations produce the exact integer product.
- R6: Each clock with `erase` low, every cell adds the product of its coefficient tap and the registered sample to its accumulator. The registered sample is loaded from `dataIn` on any clock with `dataEn` high.
- R7: Each clock with `erase` high, every accumulator is loaded with its new product, and the old sum is discarded.
- R8: With `dataEn` low, the registered sample holds its value. Products keep using the held sample.
- R9: The four accumulators update independently in the same clock. Cell k occupies bits [26k+25:26k] of `accOut`.
- R10: Each 17-bit product is sign-extended to 26 bits before it is added. Accumulation wraps modulo 2^26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coefIn | input | 8 | Coefficient entering the first cell |
| coefEn | input | 1 | Shift enable for the coefficient chain |
| dataIn | input | 8 | Sample broadcast to all cells |
| dataEn | input | 1 | Load enable for the sample register |
| coefSigned | input | 1 | 1: coefficients are two's complement |
| dataSigned | input | 1 | 1: samples are two's complement |
| decMode | input | 2 | Coefficient delay per cell, minus one |
| erase | input | 1 | Load products instead of accumulating |
| coefOut | output | 8 | Coefficient leaving the last cell, for cascading |
| accOut | output | 104 | Four 26-bit accumulators, cell 0 in the low bits |

## Verification
The properties assume that `decMode` does not change across a clock in which the coefficient chain is held. The hold check on `coefOut` only applies in that case, because changing the mode moves the tap. The bench keeps the mode fixed for the length of each run and applies reset before switching to a new mode. The properties also assume that the sign selects are steady while an erased product is checked. The bench changes them only between runs.

// File: rtl/mac_array_pkg.sv
package mac_array_pkg;
  localparam int NCELL    = 4;
  localparam int CW       = 8;
  localparam int DW       = 8;
  localparam int ACCW     = 26;
  localparam int MAXDEPTH = 4;
  localparam int MODEW    = $clog2(MAXDEPTH);

  typedef struct packed {
    logic                coefShift;
    logic                dataLoad;
    logic                accLoad;
    logic                coefSigned;
    logic                dataSigned;
    logic [MAXDEPTH-1:0] tapSel;
  } ctrl_t;
endpackage

// File: rtl/mac_array_ctrl.sv
module mac_array_ctrl
  import mac_array_pkg::*;
(
  input  logic             coefEn,
  input  logic             dataEn,
  input  logic             erase,
  input  logic             coefSigned,
  input  logic             dataSigned,
  input  logic [MODEW-1:0] decMode,
  output ctrl_t            ctrl
);
  always_comb begin
    ctrl.coefShift  = coefEn;
    ctrl.dataLoad   = dataEn;
    ctrl.accLoad    = erase;
    ctrl.coefSigned = coefSigned;
    ctrl.dataSigned = dataSigned;
    ctrl.tapSel     = '0;
    for (int i = 0; i < MAXDEPTH; i++)
      if (decMode == MODEW'(i)) ctrl.tapSel[i] = 1'b1;
  end
endmodule

// File: rtl/mac_cell.sv
module mac_cell
  import mac_array_pkg::*;
#(
  parameter int CWID  = CW,
  parameter int DWID  = DW,
  parameter int AWID  = ACCW,
  parameter int DEPTH = MAXDEPTH
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [CWID-1:0] coefIn,
  input  logic [DWID-1:0] dataQ,
  output logic [CWID-1:0] coefTap,
  output logic [AWID-1:0] acc
);
  localparam int PW = CWID + DWID + 2;

  logic [CWID-1:0] stage [DEPTH];

  // delay line for the coefficient, one register per decimation step
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stage[s] <= '0;
      else if (ctrl.coefShift) stage[s] <= (s == 0) ? coefIn : stage[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    coefTap = '0;
    for (int s = 0; s < DEPTH; s++)
      if (ctrl.tapSel[s]) coefTap = coefTap | stage[s];
  end

  logic signed [CWID:0]  coefExt;
  logic signed [DWID:0]  dataExt;
  logic signed [PW-1:0]  product;
  logic        [AWID-1:0] productWide;

  assign coefExt     = {ctrl.coefSigned & coefTap[CWID-1], coefTap};
  assign dataExt     = {ctrl.dataSigned & dataQ[DWID-1], dataQ};
  assign product     = PW'(coefExt) * PW'(dataExt);
  assign productWide = {{(AWID-PW){product[PW-1]}}, product};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             acc <= '0;
    else if (ctrl.accLoad) acc <= productWide;
    else                   acc <= acc + productWide;
  end
endmodule

// File: rtl/mac_array_datapath.sv
module mac_array_datapath
  import mac_array_pkg::*;
#(
  parameter int NC   = NCELL,
  parameter int CWID = CW,
  parameter int DWID = DW,
  parameter int AWID = ACCW
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [CWID-1:0]  coefIn,
  input  logic [DWID-1:0]  dataIn,
  output logic [DWID-1:0]  dataQ,
  output logic [CWID-1:0]  coefOut,
  output logic [NC*AWID-1:0] accOut
);
  logic [CWID-1:0] chain [NC+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (ctrl.dataLoad) dataQ <= dataIn;
  end

  assign chain[0] = coefIn;

  for (genvar c = 0; c < NC; c++) begin : g_cell
    logic [AWID-1:0] cellAcc;
    mac_cell #(.CWID(CWID), .DWID(DWID), .AWID(AWID), .DEPTH(MAXDEPTH)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .ctrl    (ctrl),
      .coefIn  (chain[c]),
      .dataQ   (dataQ),
      .coefTap (chain[c+1]),
      .acc     (cellAcc)
    );
    assign accOut[c*AWID +: AWID] = cellAcc;
  end

  assign coefOut = chain[NC];
endmodule

// File: rtl/mac_cell_array.sv
module mac_cell_array
  import mac_array_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CW-1:0]         coefIn,
  input  logic                  coefEn,
  input  logic [DW-1:0]         dataIn,
  input  logic                  dataEn,
  input  logic                  coefSigned,
  input  logic                  dataSigned,
  input  logic [MODEW-1:0]      decMode,
  input  logic                  erase,
  output logic [CW-1:0]         coefOut,
  output logic [NCELL*ACCW-1:0] accOut
);
  ctrl_t         ctrl;
  logic [DW-1:0] dataQ;

  mac_array_ctrl u_ctrl (
    .coefEn     (coefEn),
    .dataEn     (dataEn),
    .erase      (erase),
    .coefSigned (coefSigned),
    .dataSigned (dataSigned),
    .decMode    (decMode),
    .ctrl       (ctrl)
  );

  mac_array_datapath #(.NC(NCELL), .CWID(CW), .DWID(DW), .AWID(ACCW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .coefIn  (coefIn),
    .dataIn  (dataIn),
    .dataQ   (dataQ),
    .coefOut (coefOut),
    .accOut  (accOut)
  );
endmodule

// File: rtl/mac_cell_array_checker.sv
module mac_cell_array_checker
  import mac_array_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  coefEn,
  input logic                  erase,
  input logic                  coefSigned,
  input logic                  dataSigned,
  input logic [MODEW-1:0]      decMode,
  input logic [DW-1:0]         dataQ,
  input logic [CW-1:0]         coefOut,
  input logic [NCELL*ACCW-1:0] accOut
);
  // R2: a held chain with a steady mode keeps the cascade output
  assert_hold_chain_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!coefEn ##1 $stable(decMode)) |-> $stable(coefOut));

  // R6: a zero sample adds nothing to any accumulator
  assert_zero_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!erase && dataQ == '0) |=> $stable(accOut));

  // R7: erasing with a zero sample leaves every accumulator at zero
  assert_erase_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (erase && dataQ == '0) |=> (accOut == '0));

  // R4: an erased unsigned-by-unsigned product is never negative
  assert_unsigned_nonneg_R4: assert property (@(posedge clk) disable iff (!rstN)
    (erase && !coefSigned && !dataSigned) |=>
      (!accOut[ACCW-1] && !accOut[2*ACCW-1] && !accOut[3*ACCW-1] && !accOut[4*ACCW-1]));
endmodule

bind mac_cell_array mac_cell_array_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .coefEn     (coefEn),
  .erase      (erase),
  .coefSigned (coefSigned),
  .dataSigned (dataSigned),
  .decMode    (decMode),
  .dataQ      (dataQ),
  .coefOut    (coefOut),
  .accOut     (accOut)
);

// File: tb/test_mac_cell_array.sv
`timescale 1ns/1ps
module test_mac_cell_array;
  logic         clk = 1'b0;
  logic         rstN;
  logic [7:0]   coefIn;
  logic         coefEn;
  logic [7:0]   dataIn;
  logic         dataEn;
  logic         coefSigned;
  logic         dataSigned;
  logic [1:0]   decMode;
  logic         erase;
  logic [7:0]   coefOut;
  logic [103:0] accOut;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [7:0]  hist[$];
  logic [7:0]  dqModel;
  logic [25:0] accModel [4];

  always #4 clk = ~clk;

  mac_cell_array i_mac_cell_array (.*);

  // tap of cell k per R3: value accepted (k+1)*(mode+1) shifts ago, zero if none
  function automatic logic [7:0] tapOf(int k);
    int d = (k + 1) * (int'(decMode) + 1);
    if (hist.size() >= d) return hist[hist.size() - d];
    return 8'h00;
  endfunction

  // exact product per R4 R5, extended and wrapped per R10
  function automatic logic [25:0] prodOf(logic [7:0] c, logic [7:0] d);
    int a = coefSigned ? int'($signed(c)) : int'(c);
    int b = dataSigned ? int'($signed(d)) : int'(d);
    return 26'(a * b);
  endfunction

  task automatic check(string tag, logic [25:0] act, logic [25:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    for (int k = 0; k < 4; k++) check(tag, accOut[k*26 +: 26], accModel[k]);
    check("R2 R3 coefOut", 26'(coefOut), 26'(tapOf(3)));
  endtask

  task automatic doReset();
    rstN = 1'b0; coefEn = 0; dataEn = 0; erase = 0; coefIn = 0; dataIn = 0;
    hist.delete(); dqModel = 0;
    for (int k = 0; k < 4; k++) accModel[k] = 0;
    repeat (2) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 after reset");
  endtask

  // drive at negedge, advance model across one rising edge, compare at next negedge
  task automatic step(logic [7:0] c, logic ce, logic [7:0] d, logic de, logic er, string tag);
    coefIn = c; coefEn = ce; dataIn = d; dataEn = de; erase = er;
    for (int k = 0; k < 4; k++)
      accModel[k] = (er ? 26'd0 : accModel[k]) + prodOf(tapOf(k), dqModel); // R6 R7 R9
    if (ce) hist.push_back(c);
    if (de) dqModel = d;                                                    // R8
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    decMode = 0; coefSigned = 0; dataSigned = 0;
    @(negedge clk);

    // near-exhaustive product sweep, R4 R5 R7 R10, all sign combinations
    for (int sg = 0; sg < 4; sg++) begin
      coefSigned = sg[0]; dataSigned = sg[1]; decMode = 0;
      doReset();
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++) begin
          logic [7:0] b;
          b = (j == 14) ? 8'hFF : (j == 15) ? 8'h80 : 8'(j * 17);
          step(8'(a), 1'b1, b, 1'b1, 1'b1, "R5 R7 R10 product");
        end
    end

    // decimation modes R3 with random enables R2 R8 and sparse erase R6 R7
    for (int m = 0; m < 4; m++)
      for (int sg = 0; sg < 4; sg++) begin
        coefSigned = sg[0]; dataSigned = sg[1]; decMode = 2'(m);
        doReset();
        for (int t = 0; t < 60; t++)
          step(8'($urandom), ($urandom % 4) != 0, 8'($urandom), ($urandom % 4) != 0,
               ($urandom % 8) == 0, "R3 R6 R9 accumulate");
      end

    // long accumulation with full-scale values, R6 R10
    coefSigned = 1; dataSigned = 1; decMode = 3;
    doReset();
    for (int t = 0; t < 600; t++)
      step(8'h80, 1'b1, 8'h80, 1'b1, 1'b0, "R6 R10 long sum");

    // held chain and held sample, R2 R8
    decMode = 1; coefSigned = 0; dataSigned = 0;
    doReset();
    for (int t = 0; t < 12; t++) step(8'(t + 1), 1'b1, 8'(t + 3), 1'b1, 1'b0, "R2 fill");
    for (int t = 0; t < 10; t++) step(8'hAA, 1'b0, 8'h55, 1'b0, 1'b0, "R2 R8 hold");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule